// File: doc/BRIEF.md
# Random Data FIFO Fill Controller

This block is the output stage of a random number unit. A 64-bit entropy register (a Galois linear feedback shift register) steps on every clock from reset. The controller decides when the current entropy word is copied into a small output FIFO, and a consumer drains that FIFO through a pop port.

After reset the block is dormant: entropy keeps stepping but nothing is stored. The first write to the size register starts generation, and the value written is only kept for readback. From then on the block stores one word every fixed number of cycles and keeps the FIFO topped up. It pauses while the FIFO is full and continues once a pop frees a slot.

A register write port reaches three locations:
- a mode register, whose bits all have no effect;
- the size register;
- a control register of three self-clearing action bits: full software reset, FIFO flush and cadence restart.

A registered read port returns register contents.

Top module: `rng_fill_ctrl`

## Requirements
- R1: After reset, and until the size register (address 1) is first written, no word enters the FIFO and `fifo_count` stays 0, even though the entropy register keeps stepping.
- R2: The first write to address 1 while dormant starts generation, whatever the data. The cadence counter is zeroed at that edge, so the first word is stored exactly 112 clock edges later. Further writes to address 1 while running change nothing except the value that address 1 reads back.
- R3: The entropy register is loaded with SEED (default 64'h0123_4567_89AB_CDEF) by `rst` and otherwise steps on every clock. One step shifts the register right by one bit and XORs in 64'hD800_0000_0000_0000 when the bit shifted out was 1. A stored word equals the register value in the cycle of the store. No control bit affects this register.
- R4: While running and not full, stores happen exactly PERIOD (112) edges apart, one 64-bit word per store.
- R5: While `fifo_count` equals DEPTH (8), no word is stored and the cadence counter holds its value. It resumes on the edge after a pop frees a slot.
- R6: Writes to address 0 (mode) have no effect, and address 0 always reads 0. Address 3 also reads 0.
- R7: Writing address 2 loads `reg_wdata[2:0]` into the control register for exactly one cycle, after which it reads 0. Bit 0 set means software reset: on the following edge the block returns to dormant, clears the FIFO and zeroes the cadence counter.
- R8: Control bit 1 empties the FIFO on the following edge, dropping any word stored at that edge, and leaves generation running. Control bit 2 zeroes the cadence counter on the following edge without storing.
- R9: A pop of a non-empty FIFO gives the oldest word on `pop_data` with `pop_valid` high on the next cycle. A pop of an empty FIFO gives `pop_data` = 0 with `underflow` high for that one cycle. A pop is ignored on a flush or software-reset edge.
- R10: While `rst` is high, all of the following are zero: `fifo_count`, `pop_valid`, `underflow`, `pop_data`, `reg_rdata` and the control register. `reg_rdata` is updated one cycle after `reg_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 size, 2 control, 3 spare |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Registered read data |
| pop | input | 1 | Take one word from the FIFO |
| pop_data | output | 64 | Word returned by a pop (0 on underflow) |
| pop_valid | output | 1 | `pop_data` holds a real word this cycle |
| underflow | output | 1 | The last pop found the FIFO empty |
| fifo_count | output | 4 | Words currently held |

## Verification
The assertions assume that `rst` is held for at least one edge before operation and that `reg_we` and `reg_re` are single-cycle strobes. They also rely on PERIOD being greater than 1, so that two stores can never fall on adjacent edges. The bench drives every input on the falling edge, holds `rst` for several cycles, and only writes the control register through a one-cycle strobe. A cycle-level model in the bench predicts the FIFO contents, the counts and the pop results from the stated cadence and entropy rules.

// File: rtl/rng_fill_pkg.sv
package rng_fill_pkg;
  typedef enum logic [1:0] {
    SEL_MODE  = 2'd0,
    SEL_SIZE  = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_SPARE = 2'd3
  } reg_sel_e;

  localparam int CTRL_W      = 3;
  localparam int CTRL_SOFT   = 0;
  localparam int CTRL_FLUSH  = 1;
  localparam int CTRL_RESYNC = 2;
endpackage

// File: rtl/rng_entropy_lfsr.sv
module rng_entropy_lfsr #(
  parameter int          WORD_W = 64,
  parameter logic [63:0] TAPS   = 64'hD800_0000_0000_0000,
  parameter logic [63:0] SEED   = 64'h0123_4567_89AB_CDEF
) (
  input  logic              clk,
  input  logic              rst,
  output logic [WORD_W-1:0] state
);
  localparam logic [WORD_W-1:0] TAP_MASK = TAPS[WORD_W-1:0];
  localparam logic [WORD_W-1:0] SEED_V   = SEED[WORD_W-1:0];

  logic [WORD_W-1:0] nxt;

  // Galois form: shift right, fold the taps in when a one falls out.
  always_comb begin
    nxt = {1'b0, state[WORD_W-1:1]};
    if (state[0]) nxt = nxt ^ TAP_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SEED_V;
    else     state <= nxt;
  end
endmodule

// File: rtl/rng_cadence.sv
module rng_cadence #(
  parameter int PERIOD = 112
) (
  input  logic clk,
  input  logic rst,
  input  logic start_wr,
  input  logic soft_rst,
  input  logic resync,
  input  logic room,
  output logic push,
  output logic started
);
  localparam int TICK_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [TICK_W-1:0] LAST = TICK_W'(PERIOD - 1);

  logic [TICK_W-1:0] tick;

  assign push = started && room && !soft_rst && !resync && (tick == LAST);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      started <= 1'b0;
      tick    <= '0;
    end else if (!started) begin
      if (start_wr) begin
        started <= 1'b1;
        tick    <= '0;
      end
    end else if (resync) begin
      tick <= '0;
    end else if (room) begin
      tick <= push ? '0 : tick + 1'b1;
    end
  end
endmodule

// File: rtl/rng_word_fifo.sv
module rng_word_fifo #(
  parameter int WORD_W = 64,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       wr_en,
  input  logic [WORD_W-1:0]          wr_data,
  input  logic                       rd_en,
  output logic [WORD_W-1:0]          rd_data,
  output logic                       rd_valid,
  output logic                       rd_under,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic              do_wr, do_rd, empty;

  assign full  = (level == LVL_W'(DEPTH));
  assign empty = (level == '0);
  assign do_wr = wr_en && !full && !clr;
  assign do_rd = rd_en && !empty && !clr;

  // Storage has no reset so it can map onto block RAM.
  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr     <= '0;
      rptr     <= '0;
      level    <= '0;
      rd_valid <= 1'b0;
      rd_under <= 1'b0;
      if (rst) rd_data <= '0;
    end else begin
      rd_valid <= do_rd;
      rd_under <= rd_en && empty;
      if (rd_en) rd_data <= empty ? '0 : mem[rptr];
      if (do_wr) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/rng_fill_ctrl.sv
module rng_fill_ctrl
  import rng_fill_pkg::*;
#(
  parameter int          WORD_W = 64,
  parameter int          DEPTH  = 8,
  parameter int          PERIOD = 112,
  parameter logic [63:0] SEED   = 64'h0123_4567_89AB_CDEF,
  parameter int          LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              pop,
  output logic [WORD_W-1:0] pop_data,
  output logic              pop_valid,
  output logic              underflow,
  output logic [LVL_W-1:0]  fifo_count
);
  logic [WORD_W-1:0] ent_word;
  logic [WORD_W-1:0] size_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              push_w, started_w, full_w, fifo_clr, size_wr;

  assign size_wr  = reg_we && (reg_addr == SEL_SIZE);
  assign fifo_clr = ctrl_q[CTRL_SOFT] || ctrl_q[CTRL_FLUSH];

  rng_entropy_lfsr #(.WORD_W(WORD_W), .SEED(SEED)) u_ent (
    .clk   (clk),
    .rst   (rst),
    .state (ent_word)
  );

  rng_cadence #(.PERIOD(PERIOD)) u_cad (
    .clk      (clk),
    .rst      (rst),
    .start_wr (size_wr),
    .soft_rst (ctrl_q[CTRL_SOFT]),
    .resync   (ctrl_q[CTRL_RESYNC]),
    .room     (!full_w),
    .push     (push_w),
    .started  (started_w)
  );

  rng_word_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .clr      (fifo_clr),
    .wr_en    (push_w),
    .wr_data  (ent_word),
    .rd_en    (pop),
    .rd_data  (pop_data),
    .rd_valid (pop_valid),
    .rd_under (underflow),
    .level    (fifo_count),
    .full     (full_w)
  );

  // Register file: mode writes are dropped, control bits live one cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      size_q    <= '0;
      ctrl_q    <= '0;
      reg_rdata <= '0;
    end else begin
      if (size_wr) size_q <= reg_wdata;
      ctrl_q <= (reg_we && reg_addr == SEL_CTRL) ? reg_wdata[CTRL_W-1:0] : '0;
      if (reg_re) begin
        case (reg_addr)
          SEL_SIZE: reg_rdata <= size_q;
          SEL_CTRL: reg_rdata <= {{(WORD_W-CTRL_W){1'b0}}, ctrl_q};
          default:  reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/rng_fill_chk.sv
module rng_fill_chk #(
  parameter int WORD_W = 64,
  parameter int DEPTH  = 8,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              push,
  input logic              started,
  input logic              clr,
  input logic [2:0]        ctrl,
  input logic              reg_we,
  input logic              reg_re,
  input logic [1:0]        reg_addr,
  input logic [WORD_W-1:0] reg_rdata,
  input logic              pop,
  input logic [WORD_W-1:0] pop_data,
  input logic              underflow,
  input logic [LVL_W-1:0]  fifo_count
);
  assert_dormant_empty_R1: assert property (@(posedge clk) disable iff (rst)
    !started |-> fifo_count == '0);

  assert_push_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    push |=> !push);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (fifo_count == LVL_W'(DEPTH)) |-> !push);

  assert_level_bound_R5: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= LVL_W'(DEPTH));

  assert_mode_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_re && reg_addr == 2'd0) |=> reg_rdata == '0);

  assert_ctrl_selfclear_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl != 3'd0 && !(reg_we && reg_addr == 2'd2)) |=> ctrl == 3'd0);

  assert_soft_dormant_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl[0] |=> (!started && fifo_count == '0));

  assert_empty_pop_R9: assert property (@(posedge clk) disable iff (rst)
    (pop && fifo_count == '0 && !clr) |=> (underflow && pop_data == '0));
endmodule

bind rng_fill_ctrl rng_fill_chk #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .push       (push_w),
  .started    (started_w),
  .clr        (fifo_clr),
  .ctrl       (ctrl_q),
  .reg_we     (reg_we),
  .reg_re     (reg_re),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .pop        (pop),
  .pop_data   (pop_data),
  .underflow  (underflow),
  .fifo_count (fifo_count)
);

// File: tb/sim_rng_fill_ctrl.sv
`timescale 1ns/1ps
module sim_rng_fill_ctrl;
  localparam int          DEPTH  = 8;
  localparam int          PERIOD = 112;
  localparam logic [63:0] SEED   = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] TAPS   = 64'hD800_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0, pop = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata, pop_data;
  logic        pop_valid, underflow;
  logic [3:0]  fifo_count;

  int total = 0, bad = 0, cyc = 0;
  string cur_tag = "R1";

  always #2 clk = ~clk;

  rng_fill_ctrl u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pop(pop), .pop_data(pop_data),
    .pop_valid(pop_valid), .underflow(underflow), .fifo_count(fifo_count)
  );

  function automatic logic [63:0] step(input logic [63:0] s);
    logic [63:0] n;
    n = {1'b0, s[63:1]};
    if (s[0]) n = n ^ TAPS;
    return n;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model of the stated cadence, entropy and FIFO rules.
  logic [63:0] m_lfsr, m_size, m_rdata, m_pd;
  logic [63:0] m_q[$];
  logic        m_started, m_pv, m_uf;
  logic [2:0]  m_rc;
  int          m_cnt;

  always @(posedge clk) begin
    int  pre;
    bit  push;
    if (rst) begin
      m_lfsr = SEED; m_started = 0; m_cnt = 0; m_q.delete(); m_rc = 0;
      m_size = 0; m_rdata = 0; m_pv = 0; m_uf = 0; m_pd = 0;
    end else begin
      pre = m_q.size();
      push = 0;
      m_pv = 0; m_uf = 0;
      if (reg_re) m_rdata = (reg_addr == 2'd1) ? m_size :
                            (reg_addr == 2'd2) ? {61'b0, m_rc} : 64'd0;
      if (m_rc[0]) begin
        m_started = 0; m_cnt = 0; m_q.delete();
      end else begin
        if (!m_started) begin
          if (reg_we && reg_addr == 2'd1) begin m_started = 1; m_cnt = 0; end
        end else if (m_rc[2]) begin
          m_cnt = 0;
        end else if (pre < DEPTH) begin
          if (m_cnt == PERIOD - 1) begin push = 1; m_cnt = 0; end
          else m_cnt++;
        end
        if (m_rc[1]) m_q.delete();
        else begin
          if (pop) begin
            if (pre > 0) begin m_pd = m_q.pop_front(); m_pv = 1; end
            else begin m_pd = 0; m_uf = 1; end
          end
          if (push) m_q.push_back(m_lfsr);
        end
      end
      if (reg_we && reg_addr == 2'd1) m_size = reg_wdata;
      m_rc = (reg_we && reg_addr == 2'd2) ? reg_wdata[2:0] : 3'd0;
      m_lfsr = step(m_lfsr);
    end
  end

  // Continuous comparison away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      chk(fifo_count == 4'(m_q.size()), {cur_tag, " level"}, 64'(fifo_count), 64'(m_q.size()));
      chk(pop_valid == m_pv && underflow == m_uf, {cur_tag, " R9 pop flags"},
          {62'd0, pop_valid, underflow}, {62'd0, m_pv, m_uf});
      if (m_pv || m_uf) chk(pop_data == m_pd, {cur_tag, " R3 word"}, pop_data, m_pd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [63:0] exp, input string tag);
    reg_re = 1; reg_addr = a;
    @(negedge clk);
    reg_re = 0;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic pops(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      pop = 1; @(negedge clk); pop = 0;
      if (gap > 0) tick(gap);
    end
  endtask

  initial begin
    tick(4);
    cur_tag = "R10";
    chk(fifo_count == 0 && pop_valid == 0 && underflow == 0, "R10 reset outputs",
        {fifo_count, pop_valid, underflow}, 0);
    chk(reg_rdata == 0 && pop_data == 0, "R10 reset data", reg_rdata | pop_data, 0);
    rst = 0;
    tick(1);

    cur_tag = "R1";
    tick(400);
    chk(fifo_count == 0, "R1 dormant level", 64'(fifo_count), 0);
    pops(1, 0);
    chk(underflow == 1 && pop_data == 0, "R9 empty pop", {pop_data[62:0], underflow}, 1);
    tick(1);
    chk(underflow == 0, "R9 underflow one cycle", 64'(underflow), 0);

    cur_tag = "R6";
    wr(2'd0, '1);
    rd(2'd0, 0, "R6 mode reads zero");
    rd(2'd3, 0, "R6 spare reads zero");
    tick(150);
    chk(fifo_count == 0, "R6 mode write does not start", 64'(fifo_count), 0);

    cur_tag = "R2";
    wr(2'd1, 64'hDEAD_BEEF);
    tick(111);
    chk(fifo_count == 0, "R2 no word before 112 edges", 64'(fifo_count), 0);
    tick(1);
    chk(fifo_count == 1, "R2 first word at edge 112", 64'(fifo_count), 1);
    tick(40);
    wr(2'd1, 64'd5);
    rd(2'd1, 64'd5, "R2 size readback");

    cur_tag = "R4";
    tick(PERIOD * 8);
    chk(fifo_count == DEPTH, "R4 filled", 64'(fifo_count), DEPTH);
    cur_tag = "R5";
    tick(500);
    chk(fifo_count == DEPTH, "R5 held full", 64'(fifo_count), DEPTH);

    cur_tag = "R9";
    pops(3, 0);
    tick(PERIOD + 5);
    pops(1, 1);
    tick(PERIOD * 2);
    pops(DEPTH + 4, 1);
    cur_tag = "R5";
    tick(PERIOD * 3 + 7);
    pop = 1; tick(5); pop = 0;

    cur_tag = "R8";
    tick(PERIOD * 3);
    wr(2'd2, 64'd2);
    rd(2'd2, 64'd2, "R7 control bit visible one cycle");
    rd(2'd2, 64'd0, "R7 control self-clears");
    chk(fifo_count == 0, "R8 flush empties", 64'(fifo_count), 0);
    tick(60);
    wr(2'd2, 64'd4);
    tick(PERIOD * 2 + 30);

    cur_tag = "R7";
    wr(2'd2, 64'd1);
    tick(2);
    chk(fifo_count == 0, "R7 soft reset clears", 64'(fifo_count), 0);
    tick(300);
    chk(fifo_count == 0, "R7 soft reset dormant", 64'(fifo_count), 0);
    cur_tag = "R2";
    wr(2'd1, 64'd0);
    tick(112);
    chk(fifo_count == 1, "R2 restart with zero value", 64'(fifo_count), 1);
    cur_tag = "R3";
    pops(1, 2);
    tick(PERIOD * 4);
    pops(6, 0);
    tick(4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule